// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Frequency Divider

This block divides a fast input clock by an integer ratio that is set by a static 14-bit word. Inside, a prescaler counts either 8 or 9 input cycles per period. A short swallow count decides how many prescaler periods in each output cycle use the longer modulus of 9. A main count sets how many prescaler periods make up one full output cycle. If the main value is M and the swallow value is A, one output cycle lasts 8·M + A input cycles. Because the swallow field sits in the three low bits, this ratio is simply the ratio word read as an unsigned number.

The block is meant for fixed-frequency synthesis. The ratio word is normally tied off, or set by switches, and changes rarely. When the word does change, the new value applies from the next output cycle, so no cycle is ever cut short. Each output cycle gives one pulse that lasts eight input cycles, which is one short prescaler period. A separate flag reports a ratio word that the structure cannot divide by.

Top module: `pulse_swallow_divider`

## Requirements
- R1: With the ratio word at value R (swallow A = ratio_i[2:0], main M = ratio_i[13:3], R = 8·M + A), successive rising edges of div_o are exactly R input clock cycles apart.
- R2: Every pulse on div_o stays high for exactly 8 consecutive input clock cycles.
- R3: After reset is released, div_o first rises at the R-th rising clock edge. The ratio used for this first cycle is the one present at the first edge after release.
- R4: div_o is low while rst_ni is low. Asserting rst_ni forces div_o low at once, without waiting for a clock edge.
- R5: A new ratio word applied during an output cycle does not change that cycle's length. It sets the length of the next cycle, and the value taken is the one present at the edge where that next cycle starts.
- R6: The smallest legal ratio (56) and the largest (16383) are divided correctly. So is a ratio whose swallow count equals its main count (63, M = 7, A = 7).
- R7: ratio_bad_o is a combinational output. It is 1 exactly when the ratio word is below 56 or when A > M, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast input clock to be divided |
| rst_ni | input | 1 | Active-low reset. Assertion is asynchronous; release must be synchronous to clk_i |
| ratio_i | input | 14 | Static division ratio word: main count in [13:3], swallow count in [2:0] |
| div_o | output | 1 | One 8-cycle pulse per division cycle |
| ratio_bad_o | output | 1 | The ratio word cannot be divided correctly |

## Verification
The cycle-length and shadow-hold assertions assume a legal ratio word, meaning at least 56, where A ≤ M always holds. The cycle-length check only applies while the latched word is legal. They also assume that reset release is aligned with the clock. The stimulus draws random ratios from the legal range only, and it adds directed values at both ends of the range and at A = M. Every ratio change falls in the middle of an output cycle, never on a cycle boundary. Illegal words go only to the flag checks, and those are made while the divider is held in reset.

// File: rtl/swdiv_pkg.sv
package swdiv_pkg;

  // Smallest ratio from which every integer step is reachable: N*(N-1)
  function automatic int unsigned min_legal_ratio(input int unsigned swl_w);
    int unsigned n;
    n = 32'd1 << swl_w;
    return n * (n - 32'd1);
  endfunction

endpackage

// File: rtl/swdiv_prescaler.sv
module swdiv_prescaler #(
  parameter int unsigned SWL_W = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic swallow_i,
  output logic term_o
);
  localparam int unsigned N    = 1 << SWL_W;
  localparam int unsigned PC_W = SWL_W + 1;

  logic [PC_W-1:0] pcnt_q, pcnt_d;

  always_comb begin
    term_o = (pcnt_q == (swallow_i ? PC_W'(N) : PC_W'(N - 1)));
    pcnt_d = term_o ? '0 : pcnt_q + PC_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pcnt_q <= '0;
    else         pcnt_q <= pcnt_d;
  end

  // R1
  pcnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pcnt_q <= PC_W'(N));

  // R1
  swallow_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pcnt_q == PC_W'(N)) |-> $past(swallow_i));

endmodule

// File: rtl/swdiv_mctr.sv
module swdiv_mctr
  import swdiv_pkg::*;
#(
  parameter int unsigned SWL_W = 3,
  parameter int unsigned MAIN_W = 11
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [MAIN_W+SWL_W-1:0]   ratio_i,
  input  logic                      term_i,
  output logic                      swallow_o,
  output logic                      wrap_o
);
  localparam int unsigned RW = MAIN_W + SWL_W;
  localparam int unsigned MINR = min_legal_ratio(SWL_W);

  logic [MAIN_W-1:0] mcnt_q, mcnt_d, m_q, m_d, m_eff;
  logic [SWL_W-1:0]  a_q, a_d, a_eff;
  logic              fresh_q, fresh_d;

  always_comb begin
    m_eff     = fresh_q ? ratio_i[RW-1:SWL_W] : m_q;
    a_eff     = fresh_q ? ratio_i[SWL_W-1:0]  : a_q;
    swallow_o = mcnt_q < {{(MAIN_W-SWL_W){1'b0}}, a_eff};
    wrap_o    = term_i && (mcnt_q == m_eff - MAIN_W'(1));

    mcnt_d  = mcnt_q;
    m_d     = m_q;
    a_d     = a_q;
    fresh_d = fresh_q;
    if (term_i) mcnt_d = wrap_o ? '0 : mcnt_q + MAIN_W'(1);
    if (fresh_q || wrap_o) begin
      m_d     = ratio_i[RW-1:SWL_W];
      a_d     = ratio_i[SWL_W-1:0];
      fresh_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mcnt_q  <= '0;
      m_q     <= '0;
      a_q     <= '0;
      fresh_q <= 1'b1;
    end else begin
      mcnt_q  <= mcnt_d;
      m_q     <= m_d;
      a_q     <= a_d;
      fresh_q <= fresh_d;
    end
  end

  // Cycle-length monitor, separate from the swallow structure
  logic [RW-1:0] len_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     len_q <= '0;
    else if (wrap_o) len_q <= '0;
    else             len_q <= len_q + RW'(1);
  end

  // R1
  cycle_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_o && ({m_eff, a_eff} >= RW'(MINR))) |-> (len_q == {m_eff, a_eff} - RW'(1)));

  // R5
  shadow_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fresh_q || wrap_o) |=> ($stable(m_q) && $stable(a_q)));

endmodule

// File: rtl/swdiv_ratio_chk.sv
module swdiv_ratio_chk
  import swdiv_pkg::*;
#(
  parameter int unsigned SWL_W = 3,
  parameter int unsigned MAIN_W = 11
) (
  input  logic [MAIN_W+SWL_W-1:0] ratio_i,
  output logic                    bad_o
);
  localparam int unsigned RW = MAIN_W + SWL_W;
  localparam int unsigned MINR = min_legal_ratio(SWL_W);

  always_comb begin
    bad_o = (ratio_i < RW'(MINR)) ||
            ({{(MAIN_W-SWL_W){1'b0}}, ratio_i[SWL_W-1:0]} > ratio_i[RW-1:SWL_W]);
  end

endmodule

// File: rtl/pulse_swallow_divider.sv
module pulse_swallow_divider #(
  parameter int unsigned SWL_W = 3,
  parameter int unsigned MAIN_W = 11
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [MAIN_W+SWL_W-1:0] ratio_i,
  output logic                    div_o,
  output logic                    ratio_bad_o
);
  localparam int unsigned N = 1 << SWL_W;

  logic swallow, term, wrap;

  swdiv_prescaler #(.SWL_W(SWL_W)) presc_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .swallow_i (swallow),
    .term_o    (term)
  );

  swdiv_mctr #(.SWL_W(SWL_W), .MAIN_W(MAIN_W)) mctr_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ratio_i   (ratio_i),
    .term_i    (term),
    .swallow_o (swallow),
    .wrap_o    (wrap)
  );

  swdiv_ratio_chk #(.SWL_W(SWL_W), .MAIN_W(MAIN_W)) rchk_i (
    .ratio_i (ratio_i),
    .bad_o   (ratio_bad_o)
  );

  // Output pulse: one short prescaler period wide
  logic             div_q, div_d;
  logic [SWL_W-1:0] pw_q, pw_d;

  always_comb begin
    div_d = div_q;
    pw_d  = pw_q;
    if (wrap) begin
      div_d = 1'b1;
      pw_d  = '0;
    end else if (div_q) begin
      if (pw_q == SWL_W'(N - 1)) div_d = 1'b0;
      else                       pw_d  = pw_q + SWL_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= 1'b0;
      pw_q  <= '0;
    end else begin
      div_q <= div_d;
      pw_q  <= pw_d;
    end
  end

  assign div_o = div_q;

  // High-time monitor for the pulse-width check
  logic [SWL_W:0] hi_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    hi_cnt_q <= '0;
    else if (div_q) hi_cnt_q <= hi_cnt_q + (SWL_W+1)'(1);
    else            hi_cnt_q <= '0;
  end

  // R2
  pulse_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(div_q) |-> (hi_cnt_q == (SWL_W+1)'(N)));

endmodule

// File: tb/pulse_swallow_divider_tb.sv
module pulse_swallow_divider_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [13:0] ratio_i;
  logic        div_o, ratio_bad_o;

  always #5 clk_i = ~clk_i;

  pulse_swallow_divider dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ratio_i     (ratio_i),
    .div_o       (div_o),
    .ratio_bad_o (ratio_bad_o)
  );

  int   vecs  = 0;
  int   fails = 0;
  int   since = 0;
  logic cur   = 1'b0;
  logic prv   = 1'b0;

  function automatic bit exp_bad(input logic [13:0] r);
    return (r < 14'd56) || ({8'd0, r[2:0]} > r[13:3]);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk_i);
    since++;
    prv = cur;
    cur = div_o;
  endtask

  task automatic wait_rise(output int gap);
    do tick(); while (!(cur && !prv));
    gap   = since;
    since = 0;
  endtask

  task automatic pulse_width(output int w);
    w = 1;
    tick();
    while (cur) begin
      w++;
      tick();
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    int g, w, r_old, r_new;
    logic [13:0] flag_list [8];
    void'($urandom(32'd4711));
    rst_ni  = 1'b0;
    ratio_i = 14'd100;
    repeat (3) @(negedge clk_i);
    // R4: low during reset
    check(div_o == 1'b0, "R4", div_o, 0);

    // R7: flag checks while held in reset
    flag_list = '{14'd0, 14'd55, 14'd56, 14'd29, 14'd63, 14'd16383, 14'd57, 14'd48};
    foreach (flag_list[i]) begin
      ratio_i = flag_list[i];
      #1;
      check(ratio_bad_o == exp_bad(flag_list[i]), "R7", ratio_bad_o, exp_bad(flag_list[i]));
    end
    for (int i = 0; i < 30; i++) begin
      logic [13:0] v;
      v = 14'($urandom % 200);
      ratio_i = v;
      #1;
      check(ratio_bad_o == exp_bad(v), "R7", ratio_bad_o, exp_bad(v));
    end

    // R3: first pulse after release
    ratio_i = 14'd100;
    @(negedge clk_i);
    rst_ni = 1'b1;
    since = 0; cur = 1'b0; prv = 1'b0;
    wait_rise(g);
    check(g == 100, "R3", g, 100);

    // Chained ratio changes applied mid-cycle (just after a rise)
    r_old = 100;
    for (int i = 0; i < 26; i++) begin
      case (i)
        0: r_new = 56;
        1: r_new = 63;
        2: r_new = 57;
        3: r_new = 16383;
        4: r_new = 64;
        5: r_new = 56;
        default: r_new = 56 + int'($urandom % 1500);
      endcase
      ratio_i = 14'(r_new);
      pulse_width(w);
      check(w == 8, "R2", w, 8);
      wait_rise(g);
      if (r_old == 56 || r_old == 63 || r_old == 16383)
        check(g == r_old, "R6", g, r_old);
      else if (r_new != r_old)
        check(g == r_old, "R1 R5", g, r_old);
      else
        check(g == r_old, "R1", g, r_old);
      r_old = r_new;
    end
    pulse_width(w);
    check(w == 8, "R2", w, 8);
    wait_rise(g);
    check(g == r_old, "R1", g, r_old);

    // R4: asynchronous reset while the pulse is high
    ratio_i = 14'd200;
    rst_ni = 1'b0;
    #1;
    check(div_o == 1'b0, "R4", div_o, 0);
    @(negedge clk_i);
    check(div_o == 1'b0, "R4", div_o, 0);
    rst_ni = 1'b1;
    since = 0; cur = 1'b0; prv = 1'b0;
    wait_rise(g);
    check(g == 200, "R3", g, 200);
    pulse_width(w);
    check(w == 8, "R2", w, 8);
    wait_rise(g);
    check(g == 200, "R1", g, 200);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule